// File: doc/BRIEF.md
# Overlapping Push-Pull Drive Sequencer

This block sequences the gate-drive enables of a current-fed push-pull power stage. The stage has two main switches and one auxiliary switch that takes the current while a main switch turns off. A free-running ramp counter produces a short clock pulse once per period. That pulse restarts a PWM on-time and sets a dead interval in which every drive is low. A phase flip-flop toggles once per period, so each main switch runs at half the clock rate. Both main switches conduct together during the PWM on-time: this overlap is the boost charge interval. Outside the overlap, only the phase-selected switch conducts, and that is when energy is transferred.

The auxiliary drive runs at the full clock rate. It is high for the whole on-time and stays high for an extra, load-dependent number of cycles after the on-time ends. The extra time is taken from a digital load-demand word, so heavy demand gives a long hold and light demand a short one. A separate input forces the hold to zero. Three conditions suppress the drives:
- A peak-current trip turns off every drive until the next clock pulse.
- A demand below a fixed zero-power level disables the auxiliary drive and removes the main-switch overlap.
- A low supply-good input holds everything off and stops the ramp.

The analog comparators feed the block as synchronous single-bit inputs.

Top module: `pp_drive_seq`

## Requirements
- R1: While `rst` is high, and on the first output sample after it, all four outputs are 0. The ramp restarts at count 0 with the phase flip-flop at 0, so `main_a` is the first phase to conduct alone.
- R2: With `supply_ok` high, `osc_pulse` is high for exactly `PULSE_W` cycles of every `PERIOD`-cycle ramp period. Ramp counts `PERIOD-PULSE_W` to `PERIOD-1` are the pulse counts.
- R3: In any cycle where `osc_pulse` is high, `main_a`, `main_b` and `aux_drv` are all low. This is the minimum dead time.
- R4: The phase flip-flop inverts once per ramp period, at ramp count `PERIOD-1`. Outside the pulse and the on-time, exactly one main output is high: `main_a` when the phase is 0 and `main_b` when it is 1. Each main output therefore has a period of `2*PERIOD` cycles.
- R5: The clock pulse starts an on-time. The on-time ends at the first cycle outside the pulse in which `pwm_stop` is sampled high, and `pwm_stop` is ignored during the pulse. Both main outputs are high from the end of the pulse up to and including the output sample of the cycle in which `pwm_stop` was seen.
- R6: `aux_drv` is high during the on-time. It then stays high for exactly N more cycles, where N = (`load_demand` × `DLY_GAIN`) >> `DLY_SHIFT`, using the demand sampled in the cycle that ends the on-time. A clock pulse cuts the hold short.
- R7: If `delay_off` is high in the cycle that ends the on-time, N is 0 and `aux_drv` falls together with the main overlap.
- R8: When `pk_trip` is sampled high outside the pulse, all three drive outputs are low from the next sample until the next clock pulse, even if `pk_trip` has already fallen.
- R9: While `load_demand` < `ZP_LEVEL`, `aux_drv` is low and the main outputs never overlap: the phase-selected output alone follows the phase flip-flop.
- R10: While `supply_ok` is low, all outputs are low from the next sample on. The ramp, the phase, the on-time, the trip latch and the hold counter are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good enable from undervoltage lockout |
| pwm_stop | input | 1 | PWM comparator result that ends the on-time |
| pk_trip | input | 1 | Peak-current comparator trip |
| delay_off | input | 1 | Forces the auxiliary hold to zero |
| load_demand | input | DW | Load-demand word from the voltage loop |
| main_a | output | 1 | First main-switch drive |
| main_b | output | 1 | Second main-switch drive |
| aux_drv | output | 1 | Auxiliary-switch drive |
| osc_pulse | output | 1 | Internal clock pulse |

## Verification
The risky overlap is between the on-time ending and a peak-current trip arriving in the same cycle. In that cycle the hold counter is loaded, so the auxiliary drive would stay high, but the trip latch must hold it low until the next pulse. The random phase drives `pwm_stop` and `pk_trip` on independent odds, and a directed step asserts both in one cycle. A cycle model in the bench judges every output sample, tagging each mismatch with the rule that governs that cycle. It also checks that no hold cycle appears after the latch clears at the pulse.

// File: rtl/pp_drive_pkg.sv
package pp_drive_pkg;

  typedef struct packed {
    logic main_a;
    logic main_b;
    logic aux;
    logic osc;
  } drv_set_t;

  // Auxiliary hold length in cycles for a given demand word.
  function automatic int unsigned hold_len(input int unsigned demand,
                                           input int unsigned gain,
                                           input int unsigned shift);
    return (demand * gain) >> shift;
  endfunction

endpackage

// File: rtl/pp_ramp.sv
module pp_ramp #(
  parameter int unsigned PERIOD  = 32,
  parameter int unsigned PULSE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic pulse,
  output logic wrap
);
  localparam int unsigned CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] PSTART = CW'(PERIOD - PULSE_W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign pulse = run && (cnt >= PSTART);
  assign wrap  = run && (cnt == LAST);

  AST_RAMP_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);                                                    // R2
  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (cnt == PSTART));                               // R2
endmodule

// File: rtl/pp_pwm_core.sv
module pp_pwm_core (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pulse,
  input  logic wrap,
  input  logic stop,
  input  logic trip,
  output logic phase,
  output logic on_time,
  output logic trip_hold,
  output logic on_end
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase     <= 1'b0;
      on_time   <= 1'b0;
      trip_hold <= 1'b0;
    end else begin
      if (wrap) phase <= ~phase;
      on_time   <= pulse | (on_time & ~stop);
      trip_hold <= ~pulse & (trip_hold | trip);
    end
  end

  assign on_end = on_time & stop & ~pulse;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(phase));                              // R4
  AST_ONTIME_START: assert property (@(posedge clk) disable iff (rst)
    (run && pulse) |=> on_time);                                     // R5
  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (rst)
    (run && trip && !pulse) |=> trip_hold);                          // R8
endmodule

// File: rtl/pp_trail_dly.sv
module pp_trail_dly
  import pp_drive_pkg::*;
#(
  parameter int unsigned DW        = 6,
  parameter int unsigned DLY_GAIN  = 3,
  parameter int unsigned DLY_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          start,
  input  logic          off,
  input  logic [DW-1:0] demand,
  output logic          hold
);
  localparam int unsigned MAXD = ((2**DW - 1) * DLY_GAIN) >> DLY_SHIFT;
  localparam int unsigned DLYW = $clog2(MAXD + 2);

  logic [DLYW-1:0] cnt;
  logic [DLYW-1:0] load;

  assign load = DLYW'(hold_len(32'(demand), DLY_GAIN, DLY_SHIFT));

  always_ff @(posedge clk) begin
    if (rst || !run || clr) cnt <= '0;
    else if (start)         cnt <= off ? '0 : load;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);

  AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && !start && hold) |=> (cnt == $past(cnt) - 1'b1)); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && start && off) |=> !hold);                        // R7
endmodule

// File: rtl/pp_drive_seq.sv
module pp_drive_seq
  import pp_drive_pkg::*;
#(
  parameter int unsigned PERIOD    = 32,
  parameter int unsigned PULSE_W   = 3,
  parameter int unsigned DW        = 6,
  parameter int unsigned DLY_GAIN  = 3,
  parameter int unsigned DLY_SHIFT = 3,
  parameter int unsigned ZP_LEVEL  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          pwm_stop,
  input  logic          pk_trip,
  input  logic          delay_off,
  input  logic [DW-1:0] load_demand,
  output logic          main_a,
  output logic          main_b,
  output logic          aux_drv,
  output logic          osc_pulse
);
  localparam logic [DW-1:0] ZP_CODE = DW'(ZP_LEVEL);

  logic run, pulse, wrap, phase, on_time, trip_hold, on_end, hold;
  logic zero_pwr, gate, overlap;
  logic [1:0] main_nxt;
  drv_set_t nxt, q;

  assign run = supply_ok & ~rst;

  pp_ramp #(.PERIOD(PERIOD), .PULSE_W(PULSE_W)) u_ramp (
    .clk(clk), .rst(rst), .run(run), .pulse(pulse), .wrap(wrap)
  );

  pp_pwm_core u_core (
    .clk(clk), .rst(rst), .run(run), .pulse(pulse), .wrap(wrap),
    .stop(pwm_stop), .trip(pk_trip), .phase(phase), .on_time(on_time),
    .trip_hold(trip_hold), .on_end(on_end)
  );

  pp_trail_dly #(.DW(DW), .DLY_GAIN(DLY_GAIN), .DLY_SHIFT(DLY_SHIFT)) u_dly (
    .clk(clk), .rst(rst), .run(run), .clr(pulse), .start(on_end),
    .off(delay_off), .demand(load_demand), .hold(hold)
  );

  assign zero_pwr = (load_demand < ZP_CODE);
  assign gate     = run & ~pulse & ~trip_hold & ~pk_trip;
  assign overlap  = on_time & ~zero_pwr;

  for (genvar i = 0; i < 2; i++) begin : g_main
    localparam logic SEL = (i == 1);
    assign main_nxt[i] = gate & ((phase == SEL) | overlap);
  end

  always_comb begin
    nxt.main_a = main_nxt[0];
    nxt.main_b = main_nxt[1];
    nxt.aux    = gate & ~zero_pwr & (on_time | hold);
    nxt.osc    = run & pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign main_a    = q.main_a;
  assign main_b    = q.main_b;
  assign aux_drv   = q.aux;
  assign osc_pulse = q.osc;

  AST_DEAD_TIME: assert property (@(posedge clk) disable iff (rst)
    osc_pulse |-> (!main_a && !main_b && !aux_drv));                 // R3
  AST_TRIP_KILL: assert property (@(posedge clk) disable iff (rst)
    pk_trip |=> (!main_a && !main_b && !aux_drv));                   // R8
  AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!main_a && !main_b && !aux_drv && !osc_pulse));  // R10
  AST_ZERO_PWR: assert property (@(posedge clk) disable iff (rst)
    zero_pwr |=> (!aux_drv && !(main_a && main_b)));                 // R9
endmodule

// File: tb/tb_pp_drive_seq.sv
module tb_pp_drive_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 32, PULSE_W = 3, DW = 6;
  localparam int DLY_GAIN = 3, DLY_SHIFT = 3, ZP_LEVEL = 4;

  logic clk = 1'b0;
  logic rst, supply_ok, pwm_stop, pk_trip, delay_off;
  logic [DW-1:0] load_demand;
  logic main_a, main_b, aux_drv, osc_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_drive_seq dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .pwm_stop(pwm_stop),
    .pk_trip(pk_trip), .delay_off(delay_off), .load_demand(load_demand),
    .main_a(main_a), .main_b(main_b), .aux_drv(aux_drv), .osc_pulse(osc_pulse)
  );

  int checks = 0, errors = 0;
  bit done = 0, have_exp = 0;

  // bench model state
  int m_cnt = 0, m_dly = 0;
  bit m_q = 0, m_on = 0, m_flt = 0, m_lastdis = 0;
  bit e_a, e_b, e_aux, e_osc;
  string t_main, t_aux, t_osc;

  function automatic int hold_cycles(int d, bit dis);
    return dis ? 0 : (d * DLY_GAIN) >> DLY_SHIFT;
  endfunction

  task automatic chk(string tag, string nm, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit act, pulse, zp, trip_now, gate;
    act      = !rst && supply_ok;
    pulse    = (m_cnt >= PERIOD - PULSE_W);
    zp       = (int'(load_demand) < ZP_LEVEL);
    trip_now = m_flt || pk_trip;
    gate     = act && !pulse && !trip_now;
    e_osc = act && pulse;
    e_a   = gate && (!m_q || (m_on && !zp));
    e_b   = gate && (m_q || (m_on && !zp));
    e_aux = gate && !zp && (m_on || m_dly != 0);
    if (rst)             begin t_main = "R1"; t_aux = "R1"; t_osc = "R1"; end
    else if (!supply_ok) begin t_main = "R10"; t_aux = "R10"; t_osc = "R10"; end
    else begin
      t_osc = "R2";
      if (pulse)         begin t_main = "R3"; t_aux = "R3"; end
      else if (trip_now) begin t_main = "R8"; t_aux = "R8"; end
      else if (zp)       begin t_main = "R9"; t_aux = "R9"; end
      else begin
        t_main = m_on ? "R5" : "R4";
        t_aux  = m_on ? "R5" : (m_lastdis ? "R7" : "R6");
      end
    end
    // next state
    if (!act) begin
      m_cnt = 0; m_q = 0; m_on = 0; m_flt = 0; m_dly = 0;
    end else begin
      bit ending;
      ending = m_on && pwm_stop && !pulse;
      if (m_cnt == PERIOD - 1) m_q = !m_q;
      if (pulse) m_dly = 0;
      else if (ending) begin m_dly = hold_cycles(int'(load_demand), delay_off); m_lastdis = delay_off; end
      else if (m_dly != 0) m_dly--;
      m_on  = pulse || (m_on && !pwm_stop);
      m_flt = !pulse && (m_flt || pk_trip);
      m_cnt = (m_cnt == PERIOD - 1) ? 0 : m_cnt + 1;
    end
  endtask

  task automatic compare();
    chk(t_main, "main_a", main_a, e_a);
    chk(t_main, "main_b", main_b, e_b);
    chk(t_aux, "aux_drv", aux_drv, e_aux);
    chk(t_osc, "osc_pulse", osc_pulse, e_osc);
  endtask

  task automatic cyc(bit r, bit en, bit st, bit tr, bit dis, int dem);
    @(negedge clk);
    if (have_exp) compare();
    rst = r; supply_ok = en; pwm_stop = st; pk_trip = tr;
    delay_off = dis; load_demand = DW'(dem);
    model_step();
    have_exp = 1;
  endtask

  // directed run: stop/trip at given ramp counts of the bench model
  task automatic run_dir(int n, int dem, int stop_at, int trip_at, bit dis);
    for (int i = 0; i < n; i++)
      cyc(0, 1, m_cnt == stop_at, m_cnt == trip_at, dis, dem);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 40);
    // R10: supply low keeps everything off
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0, 40);
    // R2 R4 R5 R6: nominal, stop mid-period, heavy demand (hold 15)
    run_dir(4 * PERIOD, 40, 10, -1, 0);
    // R5: stop only inside pulse is ignored, on-time lasts whole period
    run_dir(2 * PERIOD, 40, PERIOD - 2, -1, 0);
    // R6: light demand gives short hold (hold 1)
    run_dir(2 * PERIOD, 5, 8, -1, 0);
    // R6: hold longer than rest of period is cut by the pulse
    run_dir(2 * PERIOD, 63, 20, -1, 0);
    // R7: delay forced off
    run_dir(2 * PERIOD, 63, 10, -1, 1);
    // R8: trip mid on-time, and trip in the same cycle as stop
    run_dir(2 * PERIOD, 40, 12, 5, 0);
    run_dir(2 * PERIOD, 40, 12, 12, 0);
    // R9: zero-power demand, boundary below and at threshold
    run_dir(2 * PERIOD, ZP_LEVEL - 1, 10, -1, 0);
    run_dir(2 * PERIOD, ZP_LEVEL, 10, -1, 0);
    // random mix
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 1000) == 0, ($urandom % 300) != 0, ($urandom % 8) == 0,
          ($urandom % 48) == 0, ($urandom % 12) == 0, int'($urandom % 64));
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule